// File: doc/BRIEF.md
# Corrected Error Report Filter

This block sits between a cache's error detectors and a machine-check logging register. Each incoming error event carries a line identifier, a flag that says whether the error was corrected or uncorrected, and a transaction type. For each event, the block decides whether to post it to the log. For each posted event, it builds the 16-bit error code word that the log stores.

Corrections are counted per cache line in a small fully associative tracking table. After `POST_LIMIT` corrections have been posted for a line, further corrections to that line are dropped. The posting that reaches the limit raises a filter flag in the code word, which tells software that later corrections to that line will go quiet. Uncorrected errors skip the filter completely. A synchronous clear input empties the table.

A two-state machine controls the flow. In `S_IDLE` the block accepts an event. It moves to `S_POST` when the accepted event is to be posted, and stays in `S_IDLE` when the event is suppressed. In `S_POST` the block offers the code word on the log port and accepts no events. It returns to `S_IDLE` when the log accepts the word.

Top module: `corr_err_filter`

## Requirements
- R1: An accepted uncorrected event is always posted, whatever its line's count, and its filter bit (bit 12) is 0.
- R2: For each line, the first `POST_LIMIT` accepted corrected events are posted. Any later corrected events to that line are not posted.
- R3: A corrected posting carries filter bit 12 = 1 exactly when it is that line's `POST_LIMIT`-th posting. Earlier postings carry 0.
- R4: Counts are kept per line. Up to `ENTRIES` lines (8 by default) are tracked independently when their events are interleaved.
- R5: Code bits 3:2 hold the transaction type. Input 00 (instruction) maps to 00, 01 (data) maps to 01, 10 (generic) maps to 10, and 11 (unknown) maps to 10. The value 11 never appears in the code.
- R6: In the code word, bit 8 = 1 and bits 1:0 = 01. All bits other than 12, 8, 3:2 and 1:0 are 0.
- R7: While `log_valid` is high and `log_ready` is low, `log_valid` stays high and `log_code` stays stable. `ev_ready` is low whenever `log_valid` is high.
- R8: A posted event raises `log_valid` in the cycle after it is accepted. A suppressed event leaves `log_valid` low, and `ev_ready` stays high in the next cycle.
- R9: When the table is full, a new line replaces the least-recently-updated entry. Every accepted corrected event counts as an update. The replaced line starts over from a count of zero.
- R10: While `clear` is high, `ev_ready` is low. After a clear, every line starts over from a count of zero.
- R11: After reset, `log_valid` is 0 and `ev_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous table clear |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted when high together with ev_valid |
| ev_line | input | LINE_W | Line identifier of the event |
| ev_uncorr | input | 1 | 1 = uncorrected, 0 = corrected |
| ev_ttype | input | 2 | Transaction type: 00 instr, 01 data, 10 generic, 11 unknown |
| log_valid | output | 1 | Code word offered to the log |
| log_ready | input | 1 | Log accepts the code word |
| log_code | output | 16 | Posted error code word |

## Verification
The hardest state to reach from the ports is a full table in a known recency order, followed by eviction of exactly the oldest line. To get there, the bench sends five interleaved rounds of corrections to eight lines. This drives every line past the limit, so the order of last updates is fixed. The bench then adds a ninth line. Whether the next corrections are posted or suppressed shows which line was dropped and which ones survived, in both orders. A held-off log during a pending posting covers the stall path.

// File: rtl/cef_pkg.sv
package cef_pkg;
    localparam int CODE_W   = 16;
    localparam int FILT_BIT = 12;

    typedef enum logic [1:0] {
        TT_INSTR   = 2'b00,
        TT_DATA    = 2'b01,
        TT_GENERIC = 2'b10,
        TT_UNKNOWN = 2'b11
    } ttype_e;

    function automatic logic [1:0] map_ttype(input logic [1:0] raw);
        return (raw == TT_UNKNOWN) ? TT_GENERIC : raw;
    endfunction

    function automatic logic [CODE_W-1:0] make_code(input logic [1:0] tt, input logic filt);
        logic [CODE_W-1:0] c;
        c           = '0;
        c[1:0]      = 2'b01;
        c[3:2]      = tt;
        c[8]        = 1'b1;
        c[FILT_BIT] = filt;
        return c;
    endfunction
endpackage

// File: rtl/cef_table.sv
module cef_table #(
    parameter int LINE_W     = 10,
    parameter int ENTRIES    = 8,
    parameter int POST_LIMIT = 3,
    localparam int CNT_W     = $clog2(POST_LIMIT + 1),
    localparam int RK_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [LINE_W-1:0] line,
    output logic              hit,
    output logic [CNT_W-1:0]  hit_cnt
);
    logic              vld_q  [ENTRIES];
    logic [LINE_W-1:0] line_q [ENTRIES];
    logic [CNT_W-1:0]  cnt_q  [ENTRIES];
    logic [RK_W-1:0]   rank_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [RK_W-1:0]   hit_idx, vic_idx, tgt;
    logic              any_free;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign match[g] = vld_q[g] && (line_q[g] == line);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        hit_cnt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx = RK_W'(i);
                hit_cnt = cnt_q[i];
            end
        end
    end

    // victim: lowest free slot, else the oldest rank
    always_comb begin
        any_free = 1'b0;
        vic_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (rank_q[i] == RK_W'(ENTRIES - 1) && !any_free) vic_idx = RK_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                any_free = 1'b1;
                vic_idx  = RK_W'(i);
            end
        end
        tgt = hit ? hit_idx : vic_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vld_q[i]  <= 1'b0;
                line_q[i] <= '0;
                cnt_q[i]  <= '0;
                rank_q[i] <= RK_W'(i);
            end
        end else if (upd) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (RK_W'(i) == tgt) begin
                    vld_q[i]  <= 1'b1;
                    line_q[i] <= line;
                    rank_q[i] <= '0;
                    if (!hit)
                        cnt_q[i] <= CNT_W'(1);
                    else if (cnt_q[i] < CNT_W'(POST_LIMIT))
                        cnt_q[i] <= cnt_q[i] + 1'b1;
                end else if (rank_q[i] < rank_q[tgt]) begin
                    rank_q[i] <= rank_q[i] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cef_ctrl.sv
module cef_ctrl
    import cef_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_valid,
    input  logic              post_req,
    input  logic [CODE_W-1:0] code_in,
    input  logic              log_ready,
    output logic              accept,
    output logic              ev_ready,
    output logic              log_valid,
    output logic [CODE_W-1:0] log_code
);
    typedef enum logic {S_IDLE, S_POST} state_e;
    state_e state_q, state_d;
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept && post_req) state_d = S_POST;
            S_POST: if (log_ready)          state_d = S_IDLE;
        endcase
    end

    always_comb begin
        ev_ready  = 1'b0;
        log_valid = 1'b0;
        unique case (state_q)
            S_IDLE: ev_ready  = !clear;
            S_POST: log_valid = 1'b1;
        endcase
        accept   = ev_valid && ev_ready;
        log_code = code_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  code_q <= '0;
        else if (accept && post_req) code_q <= code_in;
    end
endmodule

// File: rtl/corr_err_filter.sv
module corr_err_filter
    import cef_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int ENTRIES    = 8,
    parameter int POST_LIMIT = 3,
    localparam int CNT_W     = $clog2(POST_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_valid,
    output logic              ev_ready,
    input  logic [LINE_W-1:0] ev_line,
    input  logic              ev_uncorr,
    input  logic [1:0]        ev_ttype,
    output logic              log_valid,
    input  logic              log_ready,
    output logic [15:0]       log_code
);
    logic             accept, hit, post_req, filt;
    logic [CNT_W-1:0] hit_cnt, new_cnt;
    logic [CODE_W-1:0] code_in;

    cef_table #(.LINE_W(LINE_W), .ENTRIES(ENTRIES), .POST_LIMIT(POST_LIMIT)) i_table (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .upd(accept && !ev_uncorr), .line(ev_line),
        .hit(hit), .hit_cnt(hit_cnt)
    );

    always_comb begin
        new_cnt  = hit ? hit_cnt + 1'b1 : CNT_W'(1);
        post_req = ev_uncorr || !hit || (hit_cnt < CNT_W'(POST_LIMIT));
        filt     = !ev_uncorr && (new_cnt == CNT_W'(POST_LIMIT));
        code_in  = make_code(map_ttype(ev_ttype), filt);
    end

    cef_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear), .ev_valid(ev_valid),
        .post_req(post_req), .code_in(code_in), .log_ready(log_ready),
        .accept(accept), .ev_ready(ev_ready), .log_valid(log_valid),
        .log_code(log_code)
    );
endmodule

// File: rtl/cef_checker.sv
module cef_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic        ev_valid,
    input logic        ev_ready,
    input logic        ev_uncorr,
    input logic        log_valid,
    input logic        log_ready,
    input logic [15:0] log_code
);
    assert_uncorr_posted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_ready && ev_uncorr |=> log_valid && !log_code[12]);

    assert_tt_not_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> log_code[3:2] != 2'b11);

    assert_fixed_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> (log_code[15:13] == 3'b0 && log_code[11:9] == 3'b0 &&
                       log_code[8] && log_code[7:4] == 4'b0 && log_code[1:0] == 2'b01));

    assert_hold_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid && !log_ready |=> log_valid && $stable(log_code));

    assert_stall_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> !ev_ready);

    assert_clear_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !ev_ready);
endmodule

bind corr_err_filter cef_checker i_cef_checker (
    .clk(clk), .rst_n(rst_n), .clear(clear), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_uncorr(ev_uncorr), .log_valid(log_valid),
    .log_ready(log_ready), .log_code(log_code)
);

// File: tb/test_corr_err_filter.sv
`timescale 1ns/1ps
module test_corr_err_filter;
    localparam int LINE_W = 10;
    localparam int LIMIT  = 3;

    logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
    logic ev_valid = 1'b0, ev_uncorr = 1'b0, log_ready = 1'b1;
    logic [LINE_W-1:0] ev_line = '0;
    logic [1:0] ev_ttype = 2'b00;
    logic ev_ready, log_valid;
    logic [15:0] log_code;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    corr_err_filter #(.LINE_W(LINE_W), .ENTRIES(8), .POST_LIMIT(LIMIT)) i_corr_err_filter (
        .clk(clk), .rst_n(rst_n), .clear(clear), .ev_valid(ev_valid), .ev_ready(ev_ready),
        .ev_line(ev_line), .ev_uncorr(ev_uncorr), .ev_ttype(ev_ttype),
        .log_valid(log_valid), .log_ready(log_ready), .log_code(log_code)
    );

    function automatic logic [15:0] exp_code(input logic [1:0] tt, input logic f);
        logic [1:0] m;
        m = (tt == 2'b11) ? 2'b10 : tt;
        return (16'(f) << 12) | 16'h0100 | (16'(m) << 2) | 16'h0001;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input string req, input int line, input logic unc, input logic [1:0] tt,
                        input logic exp_post, input logic exp_f);
        @(negedge clk);
        ev_valid = 1'b1; ev_line = LINE_W'(line); ev_uncorr = unc; ev_ttype = tt;
        #1 check({req, " ev_ready before accept"}, 32'(ev_ready), 32'd1);
        @(negedge clk);
        ev_valid = 1'b0;
        check({req, " R8 log_valid after accept"}, 32'(log_valid), 32'(exp_post));
        if (exp_post) begin
            check({req, " code"}, 32'(log_code), 32'(exp_code(tt, exp_f)));
            if (log_ready) begin
                @(negedge clk);
                check({req, " R7 log_valid drops after accept"}, 32'(log_valid), 32'd0);
            end
        end else begin
            check({req, " R8 ev_ready after suppressed"}, 32'(ev_ready), 32'd1);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 log_valid reset", 32'(log_valid), 32'd0);
        check("R11 ev_ready reset", 32'(ev_ready), 32'd1);

        // R1 R5 R6: uncorrected, every transaction type
        for (int t = 0; t < 4; t++) send("R1 R5 R6 uncorr", 5, 1'b1, 2'(t), 1'b1, 1'b0);

        // R2 R3 R4: interleaved corrections on 8 lines
        for (int k = 0; k < LIMIT + 2; k++)
            for (int ln = 0; ln < 8; ln++)
                send("R2 R3 R4 corr", ln, 1'b0, 2'(ln % 4), k < LIMIT, k == LIMIT - 1);

        // R1: uncorrected on a suppressed line
        send("R1 uncorr on filtered line", 3, 1'b1, 2'b01, 1'b1, 1'b0);

        // R9: LRU order is 0..7 (0 oldest)
        send("R9 new line evicts oldest", 100, 1'b0, 2'b00, 1'b1, 1'b0);
        send("R9 line1 kept", 1, 1'b0, 2'b00, 1'b0, 1'b0);
        send("R9 line0 restarted", 0, 1'b0, 2'b01, 1'b1, 1'b0);
        send("R9 line2 evicted", 2, 1'b0, 2'b10, 1'b1, 1'b0);
        send("R9 line4 kept", 4, 1'b0, 2'b00, 1'b0, 1'b0);

        // R10: clear
        @(negedge clk);
        clear = 1'b1; ev_valid = 1'b1; ev_line = 10'd4; ev_uncorr = 1'b0;
        #1 check("R10 ev_ready low during clear", 32'(ev_ready), 32'd0);
        @(negedge clk);
        clear = 1'b0; ev_valid = 1'b0;
        check("R10 nothing posted during clear", 32'(log_valid), 32'd0);
        for (int k = 0; k < LIMIT; k++)
            send("R10 line4 after clear", 4, 1'b0, 2'b11, 1'b1, k == LIMIT - 1);
        send("R10 line4 suppressed again", 4, 1'b0, 2'b11, 1'b0, 1'b0);

        // R7: backpressure
        log_ready = 1'b0;
        send("R7 post with stall", 9, 1'b0, 2'b01, 1'b1, 1'b0);
        held = log_code;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R7 log_valid held", 32'(log_valid), 32'd1);
            check("R7 code stable", 32'(log_code), 32'(held));
            check("R7 ev_ready low while pending", 32'(ev_ready), 32'd0);
        end
        log_ready = 1'b1;
        @(negedge clk);
        check("R7 released", 32'(log_valid), 32'd0);
        check("R7 ev_ready back", 32'(ev_ready), 32'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule